// File: doc/BRIEF.md
# Timestamped Edge Event Queue

This block keeps a record of serviced digital-input events in arrival order. Each event names the input line that fired, a number from 1 upward, and the block stamps it with the value of a free-running 64-bit cycle counter at the moment of capture. A consumer pops events one at a time. Each pop returns the oldest line number and its stamp. Line 0 is reserved to mean "nothing there", so a pop of an empty queue returns line 0 and raises no separate flag. A flush input discards everything held.

When the configured interrupt number `irq_cfg` is zero, the block is in polled mode and the queue is bypassed. A pop then takes the lowest pending line that an external line scanner presents on `scan_line`. It returns that line and pulses a clear request back to the scanner for it, unless the line is 0.

The capture side is a valid/ready stream whose `cap_ready` is always high. Overflow is not back-pressured. Instead, a full ring is silently overwritten. The pop side is a request with a one-cycle response: `rsp_valid` is high in the clock cycle after each accepted `pop_req`. The response is not held, so the consumer must take it in that cycle.

Top module: `evq_top`

## Requirements
- R1: `cap_ready` is always 1 once out of reset. Every `pop_req` sampled at a clock edge yields `rsp_valid`=1 with `rsp_line` and `rsp_stamp` for exactly the following cycle; with no pop, `rsp_valid`=0 and `rsp_line`=0.
- R2: The timestamp counter is 0 in reset and increments by 1 on every clock edge after it. A captured entry stores the counter value present just before the capture edge.
- R3: In interrupt mode (`irq_cfg`≠0), pops return captured entries oldest first, each with its own stamp.
- R4: A pop when the read pointer equals the write pointer returns `rsp_line`=0 and leaves `rsp_stamp` at its previous value.
- R5: Both pointers wrap from DEPTH-1 to 0, so order is kept across the end of the ring.
- R6: There is no overflow protection. After DEPTH captures without a pop the queue reads as empty. After DEPTH+1 captures only the newest entry can be popped.
- R7: `flush` sets both pointers to 0. A capture in a flush cycle is discarded, and a queue pop in a flush cycle returns line 0.
- R8: In polled mode (`irq_cfg`=0), a pop returns `scan_line` as `rsp_line`. If that line is nonzero, it drives `scan_clr_valid`=1 with `scan_clr_line` equal to it in the response cycle. The queue contents and pointers are not touched.
- R9: A polled pop with `scan_line`=0 returns line 0 and raises no clear.
- R10: A capture whose `cap_line` is 0 stores nothing.
- R11: A capture and a pop in the same cycle both complete, and the pop reads the entry at the old read pointer. On an empty queue this returns 0 and the new entry stays queued.
- R12: In reset `rsp_valid`, `rsp_line`, `rsp_stamp` and `scan_clr_valid` are 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_cfg | input | 8 | Configured interrupt number; 0 selects polled mode |
| cap_valid | input | 1 | Capture stream valid |
| cap_ready | output | 1 | Capture stream ready, always 1 |
| cap_line | input | 8 | Line number of the captured event (1-based) |
| pop_req | input | 1 | Request to pop one event |
| rsp_valid | output | 1 | Pop response present (one cycle after request) |
| rsp_line | output | 8 | Popped line number, 0 when none |
| rsp_stamp | output | 64 | Timestamp of the last entry popped from the queue |
| flush | input | 1 | Empty the queue |
| scan_line | input | 8 | Lowest pending line from the external scanner, 0 if none |
| scan_clr_valid | output | 1 | Clear request to the scanner |
| scan_clr_line | output | 8 | Line to clear |

## Verification
The bench builds the block with DEPTH=8, keeping the 8-bit line and 64-bit stamp widths. With this depth, wrapping both pointers takes only a handful of captures. The silent overwrite of a full ring also comes within reach: eight captures that make the queue look empty, and a ninth that leaves only the newest entry poppable. Stamps are checked against a cycle count the bench keeps from reset.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // Which path produced the current pop response.
  typedef enum logic {
    SRC_QUEUE = 1'b0,
    SRC_SCAN  = 1'b1
  } rsp_src_e;

  // Line value that means "no event".
  localparam int unsigned NO_LINE = 0;
endpackage

// File: rtl/evq_timebase.sv
module evq_timebase #(
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [STAMP_W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + STAMP_W'(1);
  end

  // R2: one tick per clock once reset has been released
  assert_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now == $past(now) + STAMP_W'(1));
endmodule

// File: rtl/evq_ring.sv
module evq_ring #(
  parameter int DEPTH   = 1024,
  parameter int LINE_W  = 8,
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic [STAMP_W-1:0] wr_stamp,
  input  logic               rd_en,
  output logic               rd_hit,
  output logic [LINE_W-1:0]  rd_line,
  output logic [STAMP_W-1:0] rd_stamp
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = (DEPTH == (1 << PTR_W));

  logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic               empty;
  logic [LINE_W-1:0]  mem_line  [DEPTH];
  logic [STAMP_W-1:0] mem_stamp [DEPTH];

  generate
    if (POW2) begin : g_natural_wrap
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
    end else begin : g_compare_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  assign empty = (wr_ptr == rd_ptr);

  // Storage: no reset, written only outside flush cycles.
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      mem_line[wr_ptr]  <= wr_line;
      mem_stamp[wr_ptr] <= wr_stamp;
    end
  end

  // Pointers: no full check, a write always advances.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en)           wr_ptr <= wr_nxt;
      if (rd_en && !empty) rd_ptr <= rd_nxt;
    end
  end

  // Read register: reads the old read pointer, holds when nothing is popped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit   <= 1'b0;
      rd_line  <= '0;
      rd_stamp <= '0;
    end else begin
      rd_hit <= rd_en && !empty && !flush;
      if (rd_en && !empty && !flush) begin
        rd_line  <= mem_line[rd_ptr];
        rd_stamp <= mem_stamp[rd_ptr];
      end
    end
  end

  // R7: a flush leaves both pointers at zero
  assert_flush_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0) && (rd_ptr == '0));

  // R5: a write moves the write pointer one slot, wrapping at the end
  assert_wr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=>
      (($past(wr_ptr) == PTR_W'(DEPTH - 1)) ? (wr_ptr == '0)
                                            : (wr_ptr == $past(wr_ptr) + PTR_W'(1))));

  // R4: an empty pop yields no hit and keeps the stamp
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !flush) |=> !rd_hit && $stable(rd_stamp) && $stable(rd_ptr));
endmodule

// File: rtl/evq_poll.sv
module evq_poll #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic [LINE_W-1:0] scan_line,
  output logic              clr_valid,
  output logic [LINE_W-1:0] clr_line,
  output logic [LINE_W-1:0] poll_line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_valid <= 1'b0;
      clr_line  <= '0;
      poll_line <= '0;
    end else begin
      clr_valid <= poll_en && (scan_line != LINE_W'(evq_pkg::NO_LINE));
      if (poll_en) begin
        clr_line  <= scan_line;
        poll_line <= scan_line;
      end
    end
  end

  // R9: a clear is never issued for line zero
  assert_no_zero_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_line != '0);
endmodule

// File: rtl/evq_top.sv
module evq_top #(
  parameter int DEPTH   = 1024,
  parameter int LINE_W  = 8,
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         irq_cfg,
  input  logic               cap_valid,
  output logic               cap_ready,
  input  logic [LINE_W-1:0]  cap_line,
  input  logic               pop_req,
  output logic               rsp_valid,
  output logic [LINE_W-1:0]  rsp_line,
  output logic [STAMP_W-1:0] rsp_stamp,
  input  logic               flush,
  input  logic [LINE_W-1:0]  scan_line,
  output logic               scan_clr_valid,
  output logic [LINE_W-1:0]  scan_clr_line
);
  import evq_pkg::*;

  logic               polled;
  logic               cap_take, q_pop, p_pop;
  logic [STAMP_W-1:0] now;
  logic               rd_hit;
  logic [LINE_W-1:0]  rd_line, poll_line;
  logic               rsp_valid_q;
  rsp_src_e           rsp_src_q;

  assign polled   = (irq_cfg == 8'd0);
  assign cap_take = cap_valid && (cap_line != LINE_W'(NO_LINE));
  assign q_pop    = pop_req && !polled;
  assign p_pop    = pop_req && polled;

  assign cap_ready = rst_n;

  evq_timebase #(.STAMP_W(STAMP_W)) u_time (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  evq_ring #(.DEPTH(DEPTH), .LINE_W(LINE_W), .STAMP_W(STAMP_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(cap_take), .wr_line(cap_line), .wr_stamp(now),
    .rd_en(q_pop), .rd_hit(rd_hit), .rd_line(rd_line), .rd_stamp(rsp_stamp)
  );

  evq_poll #(.LINE_W(LINE_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .poll_en(p_pop), .scan_line(scan_line),
    .clr_valid(scan_clr_valid), .clr_line(scan_clr_line), .poll_line(poll_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_src_q   <= SRC_QUEUE;
    end else begin
      rsp_valid_q <= pop_req;
      if (pop_req) rsp_src_q <= polled ? SRC_SCAN : SRC_QUEUE;
    end
  end

  always_comb begin
    rsp_line = LINE_W'(NO_LINE);
    if (rsp_valid_q) begin
      if (rsp_src_q == SRC_SCAN) rsp_line = poll_line;
      else if (rd_hit)           rsp_line = rd_line;
    end
  end
  assign rsp_valid = rsp_valid_q;

  // R1: a pop is answered in exactly the next cycle
  assert_rsp_follows_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |=> !rsp_valid && rsp_line == '0);

  // R8: a polled pop returns what the scanner showed
  assert_poll_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && irq_cfg == 8'd0) |=> rsp_line == $past(scan_line));
endmodule

// File: tb/tb_evq_top.sv
`timescale 1ns/1ps
module tb_evq_top;
  localparam int DEPTH = 8;
  localparam int LW    = 8;
  localparam int SW    = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    irq_cfg = 8'd5;
  logic          cap_valid = 1'b0;
  logic          cap_ready;
  logic [LW-1:0] cap_line = '0;
  logic          pop_req = 1'b0;
  logic          rsp_valid;
  logic [LW-1:0] rsp_line;
  logic [SW-1:0] rsp_stamp;
  logic          flush = 1'b0;
  logic [LW-1:0] scan_line = '0;
  logic          scan_clr_valid;
  logic [LW-1:0] scan_clr_line;

  always #4 clk = ~clk; // 125 MHz

  evq_top #(.DEPTH(DEPTH), .LINE_W(LW), .STAMP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_cfg(irq_cfg),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_line(cap_line),
    .pop_req(pop_req), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
    .rsp_stamp(rsp_stamp), .flush(flush), .scan_line(scan_line),
    .scan_clr_valid(scan_clr_valid), .scan_clr_line(scan_clr_line)
  );

  // Bench-side cycle count, same rule as R2.
  logic [SW-1:0] bcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 64'd1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs at a falling edge, return at the next falling edge.
  task automatic cyc(input bit c, input logic [7:0] l, input bit p, input bit f,
                     input bit poll, input logic [7:0] s);
    cap_valid = c; cap_line = l; pop_req = p; flush = f;
    irq_cfg = poll ? 8'd0 : 8'd5; scan_line = s;
    @(posedge clk); @(negedge clk);
    cap_valid = 1'b0; pop_req = 1'b0; flush = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    cyc(0, 0, 1, 0, 0, 0);
    chk(rsp_valid == 1'b1, req, rsp_valid, 1);
    chk(rsp_line == exp, req, rsp_line, exp);
  endtask

  // {cap, line[8], pop, flush, poll, scan[8], exp_valid, exp_line[8], exp_clr}
  localparam int NV = 24;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'd3,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0}, // capture
    {1'b1, 8'd7,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0},
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd3,  1'b0}, // R3 oldest first
    {1'b1, 8'd9,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd7,  1'b0}, // R11 both complete
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd9,  1'b0},
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R4 empty
    {1'b1, 8'd0,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0}, // R10 line 0
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R10 nothing stored
    {1'b1, 8'd4,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R11 empty + capture
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd4,  1'b0}, // R11 entry kept
    {1'b1, 8'd2,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0},
    {1'b1, 8'd6,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0},
    {1'b0, 8'd0,  1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0}, // R7 flush
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R7 emptied
    {1'b1, 8'd5,  1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0}, // R7 capture in flush
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R7 discarded
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd12, 1'b1, 8'd12, 1'b1}, // R8 polled
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd0,  1'b1, 8'd0,  1'b0}, // R9 nothing pending
    {1'b1, 8'd8,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0},
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 8'd3,  1'b1}, // R8 bypass
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd8,  1'b0}, // R8 queue untouched
    {1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0},
    {1'b0, 8'd0,  1'b1, 1'b1, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}, // R7 pop in flush
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 8'd0,  1'b0}  // R7
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] st_a, st_b;
    @(negedge clk); @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 1'b0, "R12 rsp_valid", rsp_valid, 0);
    chk(rsp_line == '0, "R12 rsp_line", rsp_line, 0);
    chk(rsp_stamp == '0, "R12 rsp_stamp", rsp_stamp, 0);
    chk(scan_clr_valid == 1'b0, "R12 scan_clr_valid", scan_clr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap_ready == 1'b1, "R1 cap_ready", cap_ready, 1);
    pop_expect(8'd0, "R12 queue empty after reset");

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      cyc(v[29], v[28:21], v[20], v[19], v[18], v[17:10]);
      chk(rsp_valid == v[9], $sformatf("R1 table row %0d valid", i), rsp_valid, v[9]);
      chk(rsp_line == v[8:1], $sformatf("R3 table row %0d line", i), rsp_line, v[8:1]);
      chk(scan_clr_valid == v[0], $sformatf("R8 table row %0d clear", i), scan_clr_valid, v[0]);
      if (v[0])
        chk(scan_clr_line == v[17:10], $sformatf("R8 table row %0d clear line", i),
            scan_clr_line, v[17:10]);
    end

    // R2: stamps equal the cycle count before the capture edge
    cyc(0, 0, 0, 1, 0, 0);
    st_a = bcnt; cyc(1, 8'd21, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    st_b = bcnt; cyc(1, 8'd22, 0, 0, 0, 0);
    pop_expect(8'd21, "R2 first line");
    chk(rsp_stamp == st_a, "R2 first stamp", rsp_stamp, st_a);
    pop_expect(8'd22, "R2 second line");
    chk(rsp_stamp == st_b, "R2 second stamp", rsp_stamp, st_b);
    chk(st_b - st_a == 64'd3, "R2 stamp spacing", st_b - st_a, 3);
    pop_expect(8'd0, "R4 empty after drain");
    chk(rsp_stamp == st_b, "R4 stamp held", rsp_stamp, st_b);

    // R6: DEPTH captures make the ring look empty
    cyc(0, 0, 0, 1, 0, 0);
    for (int k = 1; k <= DEPTH; k++) cyc(1, 8'(k), 0, 0, 0, 0);
    pop_expect(8'd0, "R6 full wrap reads empty");
    // R6: DEPTH+1 captures leave only the newest
    cyc(0, 0, 0, 1, 0, 0);
    for (int k = 1; k <= DEPTH + 1; k++) cyc(1, 8'(k + 40), 0, 0, 0, 0);
    pop_expect(8'(DEPTH + 41), "R6 newest survives");
    pop_expect(8'd0, "R6 nothing older");

    // R5: order kept across the end of the ring
    cyc(0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 5; k++) cyc(1, 8'(k + 60), 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) pop_expect(8'(k + 60), "R5 first pass");
    for (int k = 0; k < 6; k++) cyc(1, 8'(k + 80), 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) pop_expect(8'(k + 80), "R5 across wrap");
    pop_expect(8'd0, "R5 drained");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule